// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Flow Control

This block is the transmit half of an asynchronous serial port. A host writes characters into a single-entry holding register, and a frame sequencer moves each one into a shift register. The sequencer then sends a frame on the serial line: one low start bit, eight data bits with the LSB first, an optional even or odd parity bit, and one or two high stop bits. Bit timing comes from a one-cycle bit-rate tick supplied from outside. When no character is waiting, the line rests at mark (high) and the empty flag is set.

Around the framing sits a set of flow controls, driven by single-cycle command strobes:

- **Clear-to-send gating.** When enabled, it holds back a new character until the clear-to-send input (active low) is asserted. It is checked only between characters.
- **Break.** A break command drives the line low continuously and ignores clear-to-send. Ending the break returns the line to mark for at least one full bit time before the next start bit.
- **Disable.** A disable command lets the character on the wire finish, then stops.
- **Software reset.** A software reset aborts at once.
- **Request-to-send.** The request-to-send output (active low) is set and cleared by command. It can also drop by itself one bit time after the last character of a message, when the transmitter has been disabled.

Top module: `uart_tx_fc`

## Requirements
- R1: A frame is a low start bit, 8 data bits LSB first, then (when parity is enabled) a parity bit equal to the XOR of the data bits, inverted for odd parity, then 1 stop bit, or 2 when two-stop is selected. All stop bits are high. Each bit lasts from one bit tick to the next. The line changes only on a tick cycle, except on software reset and on break entry or exit.
- R2: Once the last stop bit ends with the holding register empty, txd_o stays high and empty_o is high.
- R3: A write clears empty_o on the next cycle. If a character is in the holding register when a stop bit ends, its start bit follows with no idle bit in between.
- R4: ready_o is high exactly when the holding register is empty. A write while it is full is discarded.
- R5: A disable strobe lets the character in progress finish completely. After that, no new character starts until an enable strobe.
- R6: A software reset strobe puts txd_o at mark on the next cycle, even mid-character. It also empties the holding register, disables the transmitter and ends any break.
- R7: With clear-to-send gating on, a character starts only at a tick where cts_ni is low.
- R8: If cts_ni goes high during a character, that character completes. The line then holds mark until cts_ni is low again.
- R9: After a start-break strobe with no character in progress, txd_o goes low within two cycles and stays low until a stop-break strobe. This holds regardless of cts_ni.
- R10: After a stop-break strobe, txd_o is high for at least one full bit time before the next start bit.
- R11: rts_no is active low. An assert-RTS strobe drives it low on the next cycle; a negate-RTS strobe (which wins if both arrive together) drives it high on the next cycle.
- R12: With automatic RTS on, suppose the transmitter is disabled when a character's final stop bit ends. Then rts_no goes high at the next bit tick, one bit time later, and stays high until an assert-RTS strobe.
- R13: After rst_ni the line is at mark, rts_no is high, ready_o and empty_o are high, and the transmitter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Character to send |
| cmd_en_i | input | 1 | Enable transmitter |
| cmd_dis_i | input | 1 | Disable after the current character |
| cmd_rst_i | input | 1 | Immediate software reset |
| cmd_brk_start_i | input | 1 | Begin break |
| cmd_brk_stop_i | input | 1 | End break |
| cmd_rts_on_i | input | 1 | Assert request-to-send |
| cmd_rts_off_i | input | 1 | Negate request-to-send |
| cfg_cts_en_i | input | 1 | Gate character starts on clear-to-send |
| cfg_auto_rts_i | input | 1 | Drop request-to-send after the final character |
| cfg_par_en_i | input | 1 | Append a parity bit |
| cfg_par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop_i | input | 1 | Two stop bits when 1 |
| cts_ni | input | 1 | Clear-to-send, active low |
| txd_o | output | 1 | Serial data line |
| rts_no | output | 1 | Request-to-send, active low |
| ready_o | output | 1 | Holding register can take a character |
| empty_o | output | 1 | Nothing queued and line idle |

## Verification
The bench goes after each edge where flow control meets framing.

- **Disable and clear-to-send mid-character.** Both are raised during a character. A design that acted on them at once would cut the frame short, and a design that ignored them would send the queued character.
- **Software reset mid-character.** A reset that waits for a character boundary leaves the line low during a zero data bit.
- **Overwrite and back-to-back loading.** An overwrite of a full holding register shows up as a wrong second character. A design that inserts an idle bit between back-to-back characters is caught by the start-edge spacing.
- **Break release and automatic RTS timing.** The bench measures the mark time after a break. It also samples request-to-send in the bit time just after the final stop bit and again in the one after. This separates an early drop, a late drop and no drop at all.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK, ST_GAP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (flush_i) begin
      full_o <= 1'b0;
    end else if (take_i) begin
      full_o <= 1'b0;
    end else if (wr_i && !full_o) begin
      full_o <= 1'b1;
      data_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          tick_i,
  input  logic          go_ok_i,
  input  logic          brk_i,
  input  logic          cfg_par_en_i,
  input  logic          cfg_par_odd_i,
  input  logic          cfg_two_stop_i,
  input  logic          hold_full_i,
  input  logic [DW-1:0] hold_data_i,
  output logic          take_o,
  output logic          char_done_o,
  output logic          idle_o,
  output logic          txd_o
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  tx_state_e     st_q;
  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          par_q, par_en_q, stop_left_q;
  logic          last_stop, at_bound;

  assign last_stop   = !stop_left_q;
  assign at_bound    = (st_q == ST_IDLE) || (st_q == ST_STOP && last_stop);
  // character boundary: only place flow control is consulted
  assign take_o      = !abort_i && tick_i && at_bound && hold_full_i && go_ok_i;
  assign char_done_o = !abort_i && tick_i && (st_q == ST_STOP) && last_stop;
  assign idle_o      = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sh_q        <= '0;
      cnt_q       <= '0;
      par_q       <= 1'b0;
      par_en_q    <= 1'b0;
      stop_left_q <= 1'b0;
    end else if (abort_i) begin
      st_q <= ST_IDLE;
    end else if (take_o) begin
      st_q        <= ST_START;
      sh_q        <= hold_data_i;
      par_q       <= (^hold_data_i) ^ cfg_par_odd_i;
      par_en_q    <= cfg_par_en_i;
      stop_left_q <= cfg_two_stop_i;
    end else begin
      case (st_q)
        ST_IDLE:  if (brk_i) st_q <= ST_BRK;
        ST_START: if (tick_i) begin
          st_q  <= ST_DATA;
          cnt_q <= '0;
        end
        ST_DATA:  if (tick_i) begin
          sh_q <= sh_q >> 1;
          if (cnt_q == CW'(DW - 1)) st_q <= par_en_q ? ST_PAR : ST_STOP;
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_PAR:   if (tick_i) st_q <= ST_STOP;
        ST_STOP:  if (tick_i) begin
          if (!last_stop) stop_left_q <= 1'b0;
          else st_q <= ST_IDLE;
        end
        ST_BRK:   if (!brk_i) st_q <= ST_GAP;
        ST_GAP:   if (tick_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      ST_BRK:   txd_o = 1'b0;
      default:  txd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic on_i,
  input  logic off_i,
  input  logic auto_en_i,
  input  logic arm_i,
  input  logic cancel_i,
  output logic rts_no
);
  logic on_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (off_i) begin
      on_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (on_i) begin
      on_q   <= 1'b1;
      pend_q <= 1'b0;
    end else if (pend_q && tick_i) begin
      on_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (arm_i && auto_en_i) begin
      pend_q <= 1'b1;
    end else if (cancel_i) begin
      pend_q <= 1'b0;
    end
  end

  assign rts_no = !on_q;
endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cmd_en_i,
  input  logic              cmd_dis_i,
  input  logic              cmd_rst_i,
  input  logic              cmd_brk_start_i,
  input  logic              cmd_brk_stop_i,
  input  logic              cmd_rts_on_i,
  input  logic              cmd_rts_off_i,
  input  logic              cfg_cts_en_i,
  input  logic              cfg_auto_rts_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_two_stop_i,
  input  logic              cts_ni,
  output logic              txd_o,
  output logic              rts_no,
  output logic              ready_o,
  output logic              empty_o
);
  logic              en_q, brk_q;
  logic              hold_full, take, char_done, idle;
  logic [DATA_W-1:0] hold_data;
  logic              go_ok, cts_ok, rts_arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      if (cmd_rst_i || cmd_dis_i) en_q <= 1'b0;
      else if (cmd_en_i)          en_q <= 1'b1;
      if (cmd_rst_i || cmd_brk_stop_i) brk_q <= 1'b0;
      else if (cmd_brk_start_i)        brk_q <= 1'b1;
    end
  end

  assign cts_ok  = !cfg_cts_en_i || !cts_ni;
  assign go_ok   = en_q && cts_ok && !brk_q;
  assign rts_arm = (char_done && !en_q) || (cmd_dis_i && idle);

  uart_tx_hold #(.DW(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (cmd_rst_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .full_o    (hold_full),
    .data_o    (hold_data)
  );

  uart_tx_frame #(.DW(DATA_W)) u_frame (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .abort_i        (cmd_rst_i),
    .tick_i         (bit_tick_i),
    .go_ok_i        (go_ok),
    .brk_i          (brk_q),
    .cfg_par_en_i   (cfg_par_en_i),
    .cfg_par_odd_i  (cfg_par_odd_i),
    .cfg_two_stop_i (cfg_two_stop_i),
    .hold_full_i    (hold_full),
    .hold_data_i    (hold_data),
    .take_o         (take),
    .char_done_o    (char_done),
    .idle_o         (idle),
    .txd_o          (txd_o)
  );

  uart_tx_rts u_rts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (bit_tick_i),
    .on_i      (cmd_rts_on_i),
    .off_i     (cmd_rts_off_i),
    .auto_en_i (cfg_auto_rts_i),
    .arm_i     (rts_arm),
    .cancel_i  (cmd_en_i || cmd_rst_i),
    .rts_no    (rts_no)
  );

  assign ready_o = !hold_full;
  assign empty_o = !hold_full && idle;
endmodule

// File: rtl/uart_tx_fc_chk.sv
module uart_tx_fc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_tick_i,
  input logic wr_i,
  input logic cmd_rst_i,
  input logic cmd_brk_stop_i,
  input logic cmd_rts_on_i,
  input logic cmd_rts_off_i,
  input logic txd_o,
  input logic rts_no,
  input logic ready_o,
  input logic empty_o
);
  // R1
  line_paced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_o != $past(txd_o)) |->
      ($past(bit_tick_i) || $past(cmd_rst_i) || !txd_o || $past(cmd_brk_stop_i, 2)));

  // R2
  empty_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> txd_o);

  // R4
  fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_i && !cmd_rst_i) |=> !ready_o);

  // R6
  soft_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rst_i |=> (txd_o && ready_o && empty_o));

  // R11
  rts_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rts_on_i && !cmd_rts_off_i) |=> !rts_no);

  // R11
  rts_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rts_off_i |=> rts_no);
endmodule

bind uart_tx_fc uart_tx_fc_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bit_tick_i     (bit_tick_i),
  .wr_i           (wr_i),
  .cmd_rst_i      (cmd_rst_i),
  .cmd_brk_stop_i (cmd_brk_stop_i),
  .cmd_rts_on_i   (cmd_rts_on_i),
  .cmd_rts_off_i  (cmd_rts_off_i),
  .txd_o          (txd_o),
  .rts_no         (rts_no),
  .ready_o        (ready_o),
  .empty_o        (empty_o)
);

// File: tb/sim_uart_tx_fc.sv
module sim_uart_tx_fc;
  localparam int CLK_PERIOD = 10;
  localparam int BT = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_tick_i = 1'b0;
  logic wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic cmd_en_i = 0, cmd_dis_i = 0, cmd_rst_i = 0, cmd_brk_start_i = 0;
  logic cmd_brk_stop_i = 0, cmd_rts_on_i = 0, cmd_rts_off_i = 0;
  logic cfg_cts_en_i = 0, cfg_auto_rts_i = 0, cfg_par_en_i = 0;
  logic cfg_par_odd_i = 0, cfg_two_stop_i = 0, cts_ni = 1;
  logic txd_o, rts_no, ready_o, empty_o;
  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_fc u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bit_tick_i(bit_tick_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i),
    .cmd_en_i(cmd_en_i), .cmd_dis_i(cmd_dis_i), .cmd_rst_i(cmd_rst_i),
    .cmd_brk_start_i(cmd_brk_start_i), .cmd_brk_stop_i(cmd_brk_stop_i),
    .cmd_rts_on_i(cmd_rts_on_i), .cmd_rts_off_i(cmd_rts_off_i),
    .cfg_cts_en_i(cfg_cts_en_i), .cfg_auto_rts_i(cfg_auto_rts_i),
    .cfg_par_en_i(cfg_par_en_i), .cfg_par_odd_i(cfg_par_odd_i),
    .cfg_two_stop_i(cfg_two_stop_i), .cts_ni(cts_ni),
    .txd_o(txd_o), .rts_no(rts_no), .ready_o(ready_o), .empty_o(empty_o)
  );

  initial begin : tick_gen
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      bit_tick_i = (c == BT - 1);
      c = (c == BT - 1) ? 0 : c + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks are entered at a falling edge and return at one.
  task automatic cmd(input int c);
    case (c)
      0: cmd_en_i = 1;
      1: cmd_dis_i = 1;
      2: cmd_rst_i = 1;
      3: cmd_brk_start_i = 1;
      4: cmd_brk_stop_i = 1;
      5: cmd_rts_on_i = 1;
      default: cmd_rts_off_i = 1;
    endcase
    @(negedge clk);
    {cmd_en_i, cmd_dis_i, cmd_rst_i, cmd_brk_start_i} = '0;
    {cmd_brk_stop_i, cmd_rts_on_i, cmd_rts_off_i} = '0;
  endtask

  task automatic write(input logic [7:0] d);
    wr_i = 1; wr_data_i = d;
    @(negedge clk);
    wr_i = 0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (txd_o && n < 400);
  endtask

  // samples start bit mid-point, then nb further bits
  task automatic rx_frame(input int nb, input int pre, output logic [11:0] v);
    v = '1;
    repeat (pre) @(negedge clk);
    v[0] = txd_o;
    for (int i = 1; i <= nb; i++) begin
      repeat (BT) @(negedge clk);
      v[i] = txd_o;
    end
  endtask

  task automatic hold_mark(input int cyc, input string req);
    bit ok = 1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (!txd_o) ok = 0;
    end
    chk(ok, req, 0, 1);
  endtask

  task automatic t_reset;
    chk(txd_o == 1, "R13 txd", txd_o, 1);
    chk(rts_no == 1, "R13 rts", rts_no, 1);
    chk(ready_o == 1, "R13 ready", ready_o, 1);
    chk(empty_o == 1, "R13 empty", empty_o, 1);
  endtask

  task automatic t_basic;
    int n; logic [11:0] v;
    cmd(0);
    write(8'hA5);
    wait_start(n);
    rx_frame(9, 2, v);
    chk(v[0] == 0, "R1 start", v[0], 0);
    chk(v[8:1] == 8'hA5, "R1 data lsb first", v[8:1], 8'hA5);
    chk(v[9] == 1, "R1 stop", v[9], 1);
    repeat (6) @(negedge clk);
    chk(empty_o && txd_o, "R2 idle after stop", {empty_o, txd_o}, 3);
  endtask

  task automatic t_parity;
    int n; logic [11:0] v;
    cfg_par_en_i = 1; cfg_two_stop_i = 1; cfg_par_odd_i = 0;
    write(8'h37);
    wait_start(n);
    rx_frame(11, 2, v);
    chk(v[8:1] == 8'h37, "R1 data par", v[8:1], 8'h37);
    chk(v[9] == 1, "R1 even parity", v[9], 1);
    chk(v[11:10] == 2'b11, "R1 two stops", v[11:10], 3);
    repeat (8) @(negedge clk);
    cfg_par_odd_i = 1;
    write(8'h3C);
    wait_start(n);
    rx_frame(11, 2, v);
    chk(v[8:1] == 8'h3C && v[9] == 1, "R1 odd parity", v[9:1], 9'h13C);
    repeat (10) @(negedge clk);
    cfg_par_en_i = 0; cfg_two_stop_i = 0; cfg_par_odd_i = 0;
  endtask

  task automatic t_b2b;
    int n; logic [11:0] v;
    write(8'h11);
    chk(empty_o == 0, "R3 empty clears on write", empty_o, 0);
    wait_start(n);
    write(8'h22);
    chk(ready_o == 0, "R4 ready low when full", ready_o, 0);
    rx_frame(9, 1, v);
    chk(v[8:1] == 8'h11, "R3 first char", v[8:1], 8'h11);
    wait_start(n);
    chk(n == 2, "R3 no idle bit between chars", n, 2);
    rx_frame(9, 2, v);
    chk(v[8:1] == 8'h22, "R3 second char", v[8:1], 8'h22);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_full;
    int n; logic [11:0] v;
    cmd(1);
    write(8'h55);
    chk(ready_o == 0, "R4 ready after write", ready_o, 0);
    write(8'hAA);
    hold_mark(3 * BT, "R5 no start while disabled");
    cmd(0);
    wait_start(n);
    rx_frame(9, 2, v);
    chk(v[8:1] == 8'h55, "R4 overwrite ignored", v[8:1], 8'h55);
    hold_mark(3 * BT, "R4 discarded char not sent");
    chk(empty_o == 1, "R4 empty after single char", empty_o, 1);
  endtask

  task automatic t_disable;
    int n; logic [11:0] v;
    write(8'h5A);
    wait_start(n);
    cmd(1);
    write(8'hC3);
    rx_frame(9, 0, v);
    chk(v[8:1] == 8'h5A && v[9] == 1, "R5 current char completes", v[9:1], 9'h15A);
    hold_mark(4 * BT, "R5 queued char held");
    chk(ready_o == 0, "R5 char still queued", ready_o, 0);
    cmd(2);
  endtask

  task automatic t_swreset;
    int n;
    cmd(0);
    write(8'h00);
    wait_start(n);
    write(8'h81);
    repeat (8) @(negedge clk);
    chk(txd_o == 0, "R6 mid char low", txd_o, 0);
    cmd(2);
    chk(txd_o == 1, "R6 abort to mark", txd_o, 1);
    chk(ready_o && empty_o, "R6 flags after abort", {ready_o, empty_o}, 3);
    hold_mark(4 * BT, "R6 stays stopped");
  endtask

  task automatic t_cts;
    int n; logic [11:0] v;
    cfg_cts_en_i = 1; cts_ni = 1;
    cmd(0);
    write(8'h96);
    hold_mark(5 * BT, "R7 blocked by cts");
    cts_ni = 0;
    wait_start(n);
    rx_frame(9, 2, v);
    chk(v[8:1] == 8'h96, "R7 sent after cts", v[8:1], 8'h96);
    repeat (6) @(negedge clk);
    write(8'h3C);
    wait_start(n);
    cts_ni = 1;
    write(8'h4B);
    rx_frame(9, 1, v);
    chk(v[8:1] == 8'h3C && v[9] == 1, "R8 char finishes", v[9:1], 9'h13C);
    hold_mark(5 * BT, "R8 mark until cts");
    cts_ni = 0;
    wait_start(n);
    rx_frame(9, 2, v);
    chk(v[8:1] == 8'h4B, "R8 resumes", v[8:1], 8'h4B);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_break;
    int lo, hi; bit ok; logic [11:0] v;
    cts_ni = 1;
    cmd(3);
    @(negedge clk);
    ok = 1;
    for (int i = 0; i < 5 * BT; i++) begin
      if (txd_o) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R9 break low with cts negated", 0, 1);
    write(8'hE7);
    cts_ni = 0;
    chk(txd_o == 0, "R9 break holds", txd_o, 0);
    cmd(4);
    lo = 0;
    while (!txd_o && lo < 20) begin @(negedge clk); lo++; end
    hi = 0;
    while (txd_o && hi < 40) begin @(negedge clk); hi++; end
    chk(hi >= BT && hi <= 2 * BT + 1, "R10 mark after break", hi, BT);
    rx_frame(9, 2, v);
    chk(v[8:1] == 8'hE7, "R10 char after break", v[8:1], 8'hE7);
    repeat (6) @(negedge clk);
    cfg_cts_en_i = 0;
  endtask

  task automatic t_rts;
    int n; logic [11:0] v;
    cfg_auto_rts_i = 1;
    cmd(5);
    chk(rts_no == 0, "R11 assert rts", rts_no, 0);
    write(8'h0F);
    wait_start(n);
    cmd(1);
    rx_frame(9, 1, v);
    chk(v[8:1] == 8'h0F, "R12 last char", v[8:1], 8'h0F);
    chk(rts_no == 0, "R12 rts during stop", rts_no, 0);
    repeat (BT) @(negedge clk);
    chk(rts_no == 0, "R12 rts not early", rts_no, 0);
    repeat (BT) @(negedge clk);
    chk(rts_no == 1, "R12 rts dropped one bit after", rts_no, 1);
    repeat (3 * BT) @(negedge clk);
    chk(rts_no == 1, "R12 rts stays negated", rts_no, 1);
    cmd(5);
    chk(rts_no == 0, "R12 reasserted by command", rts_no, 0);
    cmd(6);
    chk(rts_no == 1, "R11 negate rts", rts_no, 1);
    cfg_auto_rts_i = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_parity;
    t_b2b;
    t_full;
    t_disable;
    t_swreset;
    t_cts;
    t_break;
    t_rts;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule